// File: doc/BRIEF.md
# Stream-Detecting Line Prefetcher

This block sits beside a mid-level cache and watches the demand read line addresses that the first-level caches send down. It notices ascending or descending runs of consecutive lines inside a 4 KB page. Once a run is confirmed, each further demand on it produces up to two prefetch line addresses for lines that lie ahead in the run. Each prefetch carries a flag that sends the fill to the last-level cache only. When the flag is clear, the line also fills the mid-level cache.

How far ahead the prefetcher runs depends on how busy the memory side is. When the count of outstanding requests is low, a stream may run up to 20 lines ahead of the demand. Lines more than half that distance ahead go to the last-level cache only. When the count reaches a threshold, the distance shrinks to a short limit and every prefetch goes to the last-level cache only. A table of 32 entries holds training and confirmed streams. A page holds at most one confirmed stream in each direction. When the table is full, the least recently used entry is replaced.

A line address is a byte address divided by 64. Its low 6 bits give the line's offset within its page, and the remaining bits give the page number.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0 and `dmd_ready` is 1. Reset empties the stream table, so an access adjacent to one made before reset issues nothing.
- R2: The first access to a page issues nothing and opens a training entry. The next access to that page issues nothing unless its offset is exactly one above or one below the trained offset; a non-adjacent access only moves the trained offset. An adjacent access confirms the direction and issues the line(s) one and two steps beyond it.
- R3: Each accepted demand on a confirmed stream issues zero, one or two prefetches. The first appears on `pf_valid`/`pf_line` in the cycle after acceptance and the second in the cycle after that. `dmd_ready` is 0 while a second prefetch waits.
- R4: A stream keeps a count of lines already fetched ahead of it. Each further demand on the stream lowers the count by one (not below zero) and then issues the next one or two lines beyond it. No prefetch is more than MAX_DIST (20) lines from the demand that caused it.
- R5: No prefetch leaves the 4 KB page of its demand. Near the page edge the block issues fewer prefetches or none.
- R6: A descending stream is confirmed and advanced in the same way as an ascending one, with lines issued at lower addresses.
- R7: When `outstanding` >= LOAD_THRESH (8), every prefetch has `pf_llc_only`=1 and lies no more than NEAR_DIST (4) lines ahead. Once the load drops, the full distance applies again.
- R8: When the load is low, a prefetch more than FAR_DIST (10) lines ahead has `pf_llc_only`=1, and one at 10 lines or fewer has `pf_llc_only`=0.
- R9: The table holds 32 entries. A page touched again after 31 other new pages is still tracked. After 32 other new pages it has been evicted as least recently used.
- R10: A page holds at most one confirmed ascending stream and one confirmed descending stream. A training entry that would form a second stream in the same direction issues nothing. A stream in the other direction can form and coexists with the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | 1 | Demand line address is present |
| dmd_ready | output | 1 | Block can accept a demand this cycle |
| dmd_line | input | LINE_W (26) | Demand line address (byte address / 64) |
| outstanding | input | CNT_W (5) | Count of outstanding memory requests |
| pf_valid | output | 1 | Prefetch request is present |
| pf_line | output | LINE_W (26) | Prefetch line address |
| pf_llc_only | output | 1 | 1: fill last-level cache only; 0: fill mid-level cache as well |

## Verification
Corruption of a table entry shows up at the next demand to that page. A wrong offset or direction either silences the prefetches or sends lines to the wrong side of the demand. A wrong fetched-ahead count shifts every following prefetch address by the error. A broken replacement order shows up only after a full table's worth of new pages, when the page that should still be tracked has been forgotten or the one that should be gone still issues prefetches. A wrong distance or level decision shows in the first prefetch after the load changes.

// File: rtl/pf_pkg.sv
// Shared types of the stream prefetcher.
// Assumes 64-byte lines and 4 KB pages, so a page holds 64 lines.
package pf_pkg;
    localparam int OFS_W      = 6;
    localparam int PAGE_LINES = 1 << OFS_W;

    // state of one stream table entry
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_FWD   = 2'd2,
        ST_BWD   = 2'd3
    } st_e;

    // one candidate prefetch: valid, line offset in page, fill level
    typedef struct packed {
        logic             v;
        logic [OFS_W-1:0] ofs;
        logic             llc;
    } pf_slot_t;
endpackage

// File: rtl/pf_lookup.sv
// Stream table search. For the demand page and offset, finds:
// - a confirmed entry the demand continues (ascending: last+1, descending: last-1);
// - the page's training entry;
// - whether the page already holds a confirmed stream in either direction.
// Assumes the table keeps at most one entry of each kind per page.
// The clock and reset are used only by the checks.
module pf_lookup
    import pf_pkg::*;
#(
    parameter int NUM    = 32,
    parameter int PAGE_W = 20,
    localparam int IW    = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               st_i   [NUM],
    input  logic [PAGE_W-1:0] pg_i   [NUM],
    input  logic [OFS_W-1:0]  last_i [NUM],
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic              conf_any_o,
    output logic [IW-1:0]     conf_idx_o,
    output logic              train_any_o,
    output logic [IW-1:0]     train_idx_o,
    output logic              has_fwd_o,
    output logic              has_bwd_o
);
    logic [NUM-1:0] conf_vec, train_vec, fwd_vec, bwd_vec;

    // per-entry compares
    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        logic same_pg;
        logic [OFS_W:0] last_x, ofs_x;
        assign same_pg      = (pg_i[g] == page_i);
        assign last_x       = {1'b0, last_i[g]};
        assign ofs_x        = {1'b0, ofs_i};
        assign fwd_vec[g]   = same_pg && (st_i[g] == ST_FWD);
        assign bwd_vec[g]   = same_pg && (st_i[g] == ST_BWD);
        assign train_vec[g] = same_pg && (st_i[g] == ST_TRAIN);
        assign conf_vec[g]  = (fwd_vec[g] && (last_x + 1'b1 == ofs_x)) ||
                              (bwd_vec[g] && (ofs_x + 1'b1 == last_x));
    end

    // lowest-index priority encode of the hits
    always_comb begin
        conf_idx_o  = '0;
        train_idx_o = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (conf_vec[i])  conf_idx_o  = IW'(i);
            if (train_vec[i]) train_idx_o = IW'(i);
        end
    end

    assign conf_any_o  = |conf_vec;
    assign train_any_o = |train_vec;
    assign has_fwd_o   = |fwd_vec;
    assign has_bwd_o   = |bwd_vec;

    // R10: a page never holds two ascending or two descending streams
    p_one_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_vec));
    p_one_bwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bwd_vec));
    // R2: one training entry per page
    p_one_train_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(train_vec));
endmodule

// File: rtl/pf_lru.sv
// Least-recently-used order over the table entries, kept as one age per entry.
// The ages always form a permutation of 0..NUM-1: the touched entry becomes 0,
// and younger entries age by one. The victim is the entry of age NUM-1.
// Reset gives entry i age i, so never-used entries are consumed before used ones.
module pf_lru #(
    parameter int NUM = 32,
    localparam int IW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_i,
    input  logic [IW-1:0] touch_idx_i,
    output logic [IW-1:0] victim_o
);
    logic [IW-1:0]  age_q [NUM];
    logic [IW-1:0]  touched_age;
    logic [NUM-1:0] oldest_vec;

    assign touched_age = age_q[touch_idx_i];

    // age update on every table access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) age_q[i] <= IW'(i);
        end else if (touch_i) begin
            for (int i = 0; i < NUM; i++) begin
                if (IW'(i) == touch_idx_i)       age_q[i] <= '0;
                else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // flag the oldest entry
    for (genvar g = 0; g < NUM; g++) begin : g_old
        assign oldest_vec[g] = (age_q[g] == IW'(NUM - 1));
    end

    // encode the victim index
    always_comb begin
        victim_o = '0;
        for (int i = 0; i < NUM; i++)
            if (oldest_vec[i]) victim_o = IW'(i);
    end

    // R9: exactly one entry is the replacement candidate
    p_one_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
endmodule

// File: rtl/pf_issue.sv
// Prefetch candidate generator for one lookup.
// Given the stream direction, the demand offset and the count of lines already
// fetched ahead (after this demand), it picks the next one or two lines.
// Each line must lie within the distance limit and inside the page.
// It also picks the fill level of each line and returns the new fetched-ahead
// count. Purely combinational. Assumes MAX_DIST < 250.
module pf_issue
    import pf_pkg::*;
#(
    parameter int MAX_DIST  = 20,
    parameter int NEAR_DIST = 4,
    parameter int FAR_DIST  = 10,
    parameter int AW        = 5
) (
    input  logic             dir_bwd_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [AW-1:0]    ahead_i,
    input  logic             load_high_i,
    output pf_slot_t         slot0_o,
    output pf_slot_t         slot1_o,
    output logic [AW-1:0]    ahead_o
);
    logic [7:0] k1, k2, room, lim;

    // distances of the two candidates, room left in page, active limit
    always_comb begin
        k1   = 8'(ahead_i) + 8'd1;
        k2   = k1 + 8'd1;
        room = dir_bwd_i ? 8'(ofs_i) : 8'(PAGE_LINES - 1) - 8'(ofs_i);
        lim  = load_high_i ? 8'(NEAR_DIST) : 8'(MAX_DIST);
    end

    // candidate lines and their fill level
    always_comb begin
        slot0_o.v   = (k1 <= lim) && (k1 <= room);
        slot1_o.v   = slot0_o.v && (k2 <= lim) && (k2 <= room);
        slot0_o.ofs = dir_bwd_i ? ofs_i - k1[OFS_W-1:0] : ofs_i + k1[OFS_W-1:0];
        slot1_o.ofs = dir_bwd_i ? ofs_i - k2[OFS_W-1:0] : ofs_i + k2[OFS_W-1:0];
        slot0_o.llc = load_high_i || (k1 > 8'(FAR_DIST));
        slot1_o.llc = load_high_i || (k2 > 8'(FAR_DIST));
        ahead_o     = AW'(8'(ahead_i) + {7'd0, slot0_o.v} + {7'd0, slot1_o.v});
    end
endmodule

// File: rtl/stream_prefetcher.sv
// Stream-detecting line prefetcher, top level.
// Accepts one demand line per cycle when ready. It searches the stream table,
// then trains, confirms or advances a stream, or allocates an entry in place
// of the LRU one. A confirmed or advanced stream issues up to two prefetches
// on a single output port: the first in the cycle after acceptance and the
// second in the cycle after that. Demand input is held off while the second
// prefetch waits. Assumes 64-byte lines and 4 KB pages.
module stream_prefetcher
    import pf_pkg::*;
#(
    parameter int LINE_W      = 26,
    parameter int NUM_STREAMS = 32,
    parameter int CNT_W       = 5,
    parameter int MAX_DIST    = 20,
    parameter int NEAR_DIST   = 4,
    parameter int LOAD_THRESH = 8,
    parameter int FAR_DIST    = MAX_DIST / 2,
    localparam int PAGE_W     = LINE_W - OFS_W,
    localparam int IW         = $clog2(NUM_STREAMS),
    localparam int AW         = $clog2(MAX_DIST + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_valid,
    output logic              dmd_ready,
    input  logic [LINE_W-1:0] dmd_line,
    input  logic [CNT_W-1:0]  outstanding,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic              pf_llc_only
);
    // stream table
    st_e               st_q    [NUM_STREAMS];
    logic [PAGE_W-1:0] pg_q    [NUM_STREAMS];
    logic [OFS_W-1:0]  last_q  [NUM_STREAMS];
    logic [AW-1:0]     ahead_q [NUM_STREAMS];

    logic              accept, load_high;
    logic [PAGE_W-1:0] d_page;
    logic [OFS_W-1:0]  d_ofs;
    logic              conf_any, train_any, has_fwd, has_bwd;
    logic [IW-1:0]     conf_idx, train_idx, victim, tgt_idx;
    logic              t_fwd, t_bwd, prom_f, prom_b, iss_en, iss_bwd;
    logic [AW-1:0]     iss_ahead, ahead_out, new_ahead;
    st_e               new_st;
    pf_slot_t          slot0, slot1;

    // waiting second prefetch
    logic              pend_v, pend_llc;
    logic [LINE_W-1:0] pend_line;

    assign accept    = dmd_valid && dmd_ready;
    assign dmd_ready = !pend_v;
    assign d_page    = dmd_line[LINE_W-1:OFS_W];
    assign d_ofs     = dmd_line[OFS_W-1:0];
    assign load_high = (outstanding >= CNT_W'(LOAD_THRESH));

    pf_lookup #(.NUM(NUM_STREAMS), .PAGE_W(PAGE_W)) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_i       (st_q),
        .pg_i       (pg_q),
        .last_i     (last_q),
        .page_i     (d_page),
        .ofs_i      (d_ofs),
        .conf_any_o (conf_any),
        .conf_idx_o (conf_idx),
        .train_any_o(train_any),
        .train_idx_o(train_idx),
        .has_fwd_o  (has_fwd),
        .has_bwd_o  (has_bwd)
    );

    pf_lru #(.NUM(NUM_STREAMS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_i    (accept),
        .touch_idx_i(tgt_idx),
        .victim_o   (victim)
    );

    // choose the action for this demand: advance, promote, retrain or allocate
    always_comb begin
        t_fwd  = train_any && ({1'b0, last_q[train_idx]} + 1'b1 == {1'b0, d_ofs});
        t_bwd  = train_any && ({1'b0, d_ofs} + 1'b1 == {1'b0, last_q[train_idx]});
        prom_f = !conf_any && t_fwd && !has_fwd;
        prom_b = !conf_any && t_bwd && !has_bwd;
        iss_en = conf_any || prom_f || prom_b;
        iss_bwd = conf_any ? (st_q[conf_idx] == ST_BWD) : prom_b;
        if (conf_any && ahead_q[conf_idx] != '0) iss_ahead = ahead_q[conf_idx] - 1'b1;
        else                                     iss_ahead = '0;
        if (conf_any)       tgt_idx = conf_idx;
        else if (train_any) tgt_idx = train_idx;
        else                tgt_idx = victim;
        if (conf_any)    new_st = st_q[conf_idx];
        else if (prom_f) new_st = ST_FWD;
        else if (prom_b) new_st = ST_BWD;
        else             new_st = ST_TRAIN;
        new_ahead = iss_en ? ahead_out : '0;
    end

    pf_issue #(
        .MAX_DIST (MAX_DIST),
        .NEAR_DIST(NEAR_DIST),
        .FAR_DIST (FAR_DIST),
        .AW       (AW)
    ) u_issue (
        .dir_bwd_i  (iss_bwd),
        .ofs_i      (d_ofs),
        .ahead_i    (iss_ahead),
        .load_high_i(load_high),
        .slot0_o    (slot0),
        .slot1_o    (slot1),
        .ahead_o    (ahead_out)
    );

    // table write for the accepted demand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                st_q[i]    <= ST_FREE;
                pg_q[i]    <= '0;
                last_q[i]  <= '0;
                ahead_q[i] <= '0;
            end
        end else if (accept) begin
            st_q[tgt_idx]    <= new_st;
            pg_q[tgt_idx]    <= d_page;
            last_q[tgt_idx]  <= d_ofs;
            ahead_q[tgt_idx] <= new_ahead;
        end
    end

    // prefetch output register and the waiting second request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid    <= 1'b0;
            pf_line     <= '0;
            pf_llc_only <= 1'b0;
            pend_v      <= 1'b0;
            pend_line   <= '0;
            pend_llc    <= 1'b0;
        end else if (accept) begin
            pf_valid    <= iss_en && slot0.v;
            pf_line     <= {d_page, slot0.ofs};
            pf_llc_only <= slot0.llc;
            pend_v      <= iss_en && slot1.v;
            pend_line   <= {d_page, slot1.ofs};
            pend_llc    <= slot1.llc;
        end else if (pend_v) begin
            pf_valid    <= 1'b1;
            pf_line     <= pend_line;
            pf_llc_only <= pend_llc;
            pend_v      <= 1'b0;
        end else begin
            pf_valid    <= 1'b0;
        end
    end

    // ---------------- checks ----------------
    logic [PAGE_W-1:0] obs_page;
    logic [OFS_W-1:0]  obs_ofs, pf_ofs, pf_dist;
    logic              obs_load;

    // last accepted demand, kept for the checks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obs_page <= '0;
            obs_ofs  <= '0;
            obs_load <= 1'b0;
        end else if (accept) begin
            obs_page <= d_page;
            obs_ofs  <= d_ofs;
            obs_load <= load_high;
        end
    end

    assign pf_ofs  = pf_line[OFS_W-1:0];
    assign pf_dist = (pf_ofs > obs_ofs) ? pf_ofs - obs_ofs : obs_ofs - pf_ofs;

    // R3: a held-off demand means a second prefetch appears next cycle
    p_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dmd_ready |=> pf_valid);
    // R5: prefetches stay in the demand's page
    p_same_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pf_line[LINE_W-1:OFS_W] == obs_page);
    // R4: distance from the demand lies in 1..MAX_DIST
    p_dist_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_dist >= 1) && (pf_dist <= OFS_W'(MAX_DIST)));
    // R8: far lines go to the last-level cache only
    p_far_llc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_dist > OFS_W'(FAR_DIST)) |-> pf_llc_only);
    // R7: under high load, near and last-level only
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && obs_load) |-> (pf_llc_only && pf_dist <= OFS_W'(NEAR_DIST)));
endmodule

// File: tb/test_stream_prefetcher.sv
module test_stream_prefetcher;
    localparam int CLK_NS = 10;
    localparam int WD_CYC = 50000;

    typedef struct packed {
        int line; int outs; int n; int l0; int c0; int l1; int c1; int req;
    } vec_t;

    // demand, outstanding, expected count, line/level of first and second, requirement
    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{330, 0, 0,   0, 0,   0, 0, 2},  // R2 train page 5
        '{331, 0, 2, 332, 0, 333, 0, 2},  // R2 confirm ascending
        '{332, 0, 2, 334, 0, 335, 0, 3},  // R3 advance
        '{333, 0, 2, 336, 0, 337, 0, 4},  // R4 ahead grows
        '{600, 0, 0,   0, 0,   0, 0, 6},  // R6 train page 9
        '{599, 0, 2, 598, 0, 597, 0, 6},  // R6 confirm descending
        '{598, 0, 2, 596, 0, 595, 0, 6},  // R6 advance
        '{597, 8, 2, 594, 1, 593, 1, 7},  // R7 load high
        '{596, 9, 1, 592, 1,   0, 0, 7},  // R7 near limit reached
        '{595, 8, 1, 591, 1,   0, 0, 7},  // R7
        '{594, 0, 2, 590, 0, 589, 0, 7},  // R7 load dropped
        '{780, 0, 0,   0, 0,   0, 0, 2},  // R2 train page 12
        '{782, 0, 0,   0, 0,   0, 0, 2},  // R2 non-adjacent retrains
        '{783, 0, 2, 784, 0, 785, 0, 2},  // R2 confirm from retrained offset
        '{130, 0, 0,   0, 0,   0, 0, 5},  // R5 page 2
        '{129, 0, 1, 128, 0,   0, 0, 5},  // R5 one line left
        '{128, 0, 0,   0, 0,   0, 0, 5},  // R5 page start
        '{253, 0, 0,   0, 0,   0, 0, 5},  // R5 page 3
        '{254, 0, 1, 255, 0,   0, 0, 5},  // R5 one line left
        '{255, 0, 0,   0, 0,   0, 0, 5},  // R5 page end
        '{350, 0, 0,   0, 0,   0, 0, 10}, // R10 train in page 5
        '{351, 0, 0,   0, 0,   0, 0, 10}, // R10 second ascending refused
        '{350, 0, 2, 349, 0, 348, 0, 10}, // R10 descending forms
        '{334, 0, 2, 338, 0, 339, 0, 10}  // R10 first stream intact
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dmd_valid = 1'b0;
    logic        dmd_ready;
    logic [25:0] dmd_line = '0;
    logic [4:0]  outstanding = '0;
    logic        pf_valid;
    logic [25:0] pf_line;
    logic        pf_llc_only;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    stream_prefetcher i_stream_prefetcher (
        .clk        (clk),
        .rst_n      (rst_n),
        .dmd_valid  (dmd_valid),
        .dmd_ready  (dmd_ready),
        .dmd_line   (dmd_line),
        .outstanding(outstanding),
        .pf_valid   (pf_valid),
        .pf_line    (pf_line),
        .pf_llc_only(pf_llc_only)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one demand, then check both output cycles
    task automatic lookup(input int line, input int outs, input int n,
                          input int l0, input int c0, input int l1, input int c1,
                          input string tag);
        @(negedge clk);
        chk(dmd_ready == 1'b1, tag, "ready before demand", int'(dmd_ready), 1);
        dmd_valid   = 1'b1;
        dmd_line    = 26'(line);
        outstanding = 5'(outs);
        @(negedge clk);
        dmd_valid = 1'b0;
        chk(pf_valid == (n >= 1), tag, "first pf_valid", int'(pf_valid), int'(n >= 1));
        if (n >= 1 && pf_valid) begin
            chk(int'(pf_line) == l0, tag, "first line", int'(pf_line), l0);
            chk(int'(pf_llc_only) == c0, tag, "first level", int'(pf_llc_only), c0);
        end
        if (n == 2)
            chk(dmd_ready == 1'b0, "R3", "ready while second waits", int'(dmd_ready), 0);
        @(negedge clk);
        chk(pf_valid == (n == 2), tag, "second pf_valid", int'(pf_valid), int'(n == 2));
        if (n == 2 && pf_valid) begin
            chk(int'(pf_line) == l1, tag, "second line", int'(pf_line), l1);
            chk(int'(pf_llc_only) == c1, tag, "second level", int'(pf_llc_only), c1);
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pf_valid == 1'b0, "R1", "pf_valid in reset", int'(pf_valid), 0);
        chk(dmd_ready == 1'b1, "R1", "ready in reset", int'(dmd_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pf_valid == 1'b0, "R1", "pf_valid after reset", int'(pf_valid), 0);

        // table walk
        for (int i = 0; i < NV; i++)
            lookup(VECS[i].line, VECS[i].outs, VECS[i].n, VECS[i].l0, VECS[i].c0,
                   VECS[i].l1, VECS[i].c1, $sformatf("R%0d", VECS[i].req));

        // R4 / R8: long ascending stream in page 20, against a model of the rules
        begin
            int a;
            a = 0;
            lookup(1280, 0, 0, 0, 0, 0, 0, "R4");
            for (int o = 1; o < 64; o++) begin
                int ain, n, l0, l1, c0, c1;
                ain = (o == 1) ? 0 : ((a > 0) ? a - 1 : 0);
                n = 0; l0 = 0; l1 = 0; c0 = 0; c1 = 0;
                if (ain + 1 <= 20 && o + ain + 1 <= 63) begin
                    n = 1; l0 = 1280 + o + ain + 1; c0 = int'(ain + 1 > 10);
                    if (ain + 2 <= 20 && o + ain + 2 <= 63) begin
                        n = 2; l1 = 1280 + o + ain + 2; c1 = int'(ain + 2 > 10);
                    end
                end
                a = ain + n;
                lookup(1280 + o, 0, n, l0, c0, l1, c1, (o % 2 == 0) ? "R8" : "R4");
            end
        end

        // R9: page stays tracked across 31 new pages
        lookup(100 * 64 + 10, 0, 0, 0, 0, 0, 0, "R9");
        for (int p = 101; p < 132; p++) lookup(p * 64 + 10, 0, 0, 0, 0, 0, 0, "R9");
        lookup(100 * 64 + 11, 0, 2, 100 * 64 + 12, 0, 100 * 64 + 13, 0, "R9");
        // R9: evicted after 32 new pages
        lookup(200 * 64 + 10, 0, 0, 0, 0, 0, 0, "R9");
        for (int p = 201; p < 233; p++) lookup(p * 64 + 10, 0, 0, 0, 0, 0, 0, "R9");
        lookup(200 * 64 + 11, 0, 0, 0, 0, 0, 0, "R9");

        // R1: reset clears training
        lookup(40 * 64 + 10, 0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(40 * 64 + 11, 0, 0, 0, 0, 0, 0, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule